// File: doc/BRIEF.md
# PIM Bank-Mode Access Router

This block sits in front of the banks of one pseudo-channel of a processing-in-memory DRAM device. It holds the channel's operating mode and steers every incoming read or write command to the banks. There are three modes: single-bank, where it acts as ordinary memory routing and only the addressed bank sees a command; all-bank, where a write is spread to the whole half of the banks that share the parity of the requested bank index; and all-bank-PIM, where reads and writes are both spread by parity, the row and column go to the processing unit, and read data goes to the processing unit instead of back to the host.

In all-bank-PIM mode the data written into the banks comes from the processing unit's result port. Whatever data the host supplied is dropped. Each command accepted in that mode sends the processing unit a one-cycle trigger that carries a read/write flag. The mode moves one step at a time through a separate request input: single-bank to all-bank to PIM, and back down the same way. A request that skips a step or names the current mode is refused and flagged for one cycle.

Top module: `pim_bank_router`

## Requirements
- R1: After reset the mode output reads single-bank (code 0), and every registered output (bank enables, write enable, write data, trigger) is zero.
- R2: In single-bank mode (code 0), a command accepted on a clock edge drives, after that edge, a bank enable with only bit `cmd_bank` set, `bank_we` equal to `cmd_write`, and, for a write, `bank_wdata` equal to the host data.
- R3: In all-bank mode (code 1), a write enables every bank whose index has the same parity as `cmd_bank` (0x5555 for even, 0xAAAA for odd) and carries the host data.
- R4: In all-bank mode a read enables only the addressed bank.
- R5: In all-bank-PIM mode (code 2), reads and writes both enable the parity group of `cmd_bank`, and a write carries `pu_wdata` in place of the host data.
- R6: A mode request succeeds only if it moves one step: code 0 to 1, 1 to 2, 2 to 1 or 1 to 0. Any other request, including one that names the current mode or code 3, leaves the mode unchanged and raises `mode_err` for exactly one cycle.
- R7: `pu_trig` pulses for one cycle after each command accepted in all-bank-PIM mode. With the pulse come `pu_trig_write`, `pu_row` and `pu_col`. In other modes the trigger and the processing-unit address outputs stay zero.
- R8: Returned bank read data (`bank_rvalid`) goes to the processing-unit read port while the mode is all-bank-PIM. In any other mode it goes to the host read port. The port that is not selected shows valid low and data zero.
- R9: A command that arrives on the same edge as a mode request is routed by the mode that held before that request.
- R10: On the edge after a cycle with no command, the bank enables and `bank_we` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req_valid | input | 1 | Mode-change request strobe |
| mode_req_target | input | 2 | Requested mode: 0 single, 1 all-bank, 2 PIM |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 4 | Requested bank index |
| cmd_row | input | 14 | Row address |
| cmd_col | input | 5 | Column address |
| host_wdata | input | 256 | Host write data |
| pu_wdata | input | 256 | Processing-unit result data |
| bank_rvalid | input | 1 | Read data returned by the banks is valid |
| bank_rdata | input | 256 | Read data returned by the banks |
| mode_cur | output | 2 | Current mode |
| mode_err | output | 1 | One-cycle flag for a refused mode request |
| bank_en | output | 16 | Per-bank command enable |
| bank_we | output | 1 | Write enable for the enabled banks |
| bank_row | output | 14 | Row address toward the banks |
| bank_col | output | 5 | Column address toward the banks |
| bank_wdata | output | 256 | Data to be written into the enabled banks |
| pu_trig | output | 1 | One-cycle trigger to the processing unit |
| pu_trig_write | output | 1 | Trigger belongs to a write |
| pu_row | output | 14 | Row address for the processing unit |
| pu_col | output | 5 | Column address for the processing unit |
| pu_rvalid | output | 1 | Bank read data valid toward the processing unit |
| pu_rdata | output | 256 | Bank read data toward the processing unit |
| host_rvalid | output | 1 | Bank read data valid toward the host |
| host_rdata | output | 256 | Bank read data toward the host |

## Verification
The hardest case to reach from the ports is a command that lands on the same edge as a mode step. To separate the routing by the old mode from routing by the new one, the stimulus sets up the step from all-bank into PIM and issues a write in that cycle. Both modes broadcast this write to the same parity group, so the bank enables are the same either way. The write data and the trigger are what show which mode was used: host data with no trigger means the old mode held. To reach the PIM modes at all, the bench has to walk the legal ladder. It also fires refused requests at each rung and checks that the mode output stays put.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  typedef enum logic [1:0] {
    MODE_SB  = 2'd0,
    MODE_AB  = 2'd1,
    MODE_ABP = 2'd2
  } pbr_mode_e;

  // A request is legal only when it moves exactly one rung up or down.
  function automatic logic step_legal(input logic [1:0] cur, input logic [1:0] tgt);
    logic up_ok;
    logic dn_ok;
    up_ok = (cur != MODE_ABP) && (tgt == cur + 2'd1);
    dn_ok = (cur != MODE_SB)  && (tgt == cur - 2'd1);
    return up_ok || dn_ok;
  endfunction

  // Broadcast applies to every access in PIM mode and to writes in all-bank mode.
  function automatic logic use_broadcast(input logic [1:0] mode, input logic is_write);
    return (mode == MODE_ABP) || ((mode == MODE_AB) && is_write);
  endfunction

endpackage

// File: rtl/pbr_mode_ctl.sv
module pbr_mode_ctl
  import pbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_target,
  output pbr_mode_e  mode_q,
  output logic       err_q
);

  logic step_ok;
  assign step_ok = step_legal(mode_q, req_target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_SB;
      err_q  <= 1'b0;
    end else begin
      err_q <= req_valid && !step_ok;
      if (req_valid && step_ok) mode_q <= pbr_mode_e'(req_target);
    end
  end

  // R6
  abp_from_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ABP && $past(mode_q) != MODE_ABP) |-> $past(mode_q) == MODE_AB);

  // R6
  err_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> mode_q == $past(mode_q));

  // R6
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);

endmodule

// File: rtl/pbr_bank_fanout.sv
module pbr_bank_fanout
  import pbr_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [1:0]          mode,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic [BANK_W-1:0]   cmd_bank,
  output logic [NUM_BANKS-1:0] en
);

  logic bcast;
  assign bcast = use_broadcast(mode, cmd_write);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic PAR = 1'(b % 2);
    logic hit_one;
    logic hit_par;
    assign hit_one = (cmd_bank == BANK_W'(b));
    assign hit_par = (cmd_bank[0] == PAR);
    assign en[b]   = cmd_valid && (bcast ? hit_par : hit_one);
  end

endmodule

// File: rtl/pim_bank_router.sv
module pim_bank_router
  import pbr_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int DATA_W    = 256,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_req_valid,
  input  logic [1:0]           mode_req_target,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [ROW_W-1:0]     cmd_row,
  input  logic [COL_W-1:0]     cmd_col,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic [DATA_W-1:0]    pu_wdata,
  input  logic                 bank_rvalid,
  input  logic [DATA_W-1:0]    bank_rdata,
  output logic [1:0]           mode_cur,
  output logic                 mode_err,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic                 bank_we,
  output logic [ROW_W-1:0]     bank_row,
  output logic [COL_W-1:0]     bank_col,
  output logic [DATA_W-1:0]    bank_wdata,
  output logic                 pu_trig,
  output logic                 pu_trig_write,
  output logic [ROW_W-1:0]     pu_row,
  output logic [COL_W-1:0]     pu_col,
  output logic                 pu_rvalid,
  output logic [DATA_W-1:0]    pu_rdata,
  output logic                 host_rvalid,
  output logic [DATA_W-1:0]    host_rdata
);

  localparam int HALF = NUM_BANKS / 2;

  pbr_mode_e                mode_q;
  logic [NUM_BANKS-1:0]     en_d;
  logic                     in_pim;
  logic [1:0]               issued_mode_q;   // mode that routed the current outputs

  pbr_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (mode_req_valid),
    .req_target (mode_req_target),
    .mode_q     (mode_q),
    .err_q      (mode_err)
  );

  pbr_bank_fanout #(.NUM_BANKS(NUM_BANKS)) u_fanout (
    .mode      (mode_q),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_bank  (cmd_bank),
    .en        (en_d)
  );

  assign in_pim   = (mode_q == MODE_ABP);
  assign mode_cur = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_en       <= '0;
      bank_we       <= 1'b0;
      bank_row      <= '0;
      bank_col      <= '0;
      bank_wdata    <= '0;
      pu_trig       <= 1'b0;
      pu_trig_write <= 1'b0;
      pu_row        <= '0;
      pu_col        <= '0;
      issued_mode_q <= MODE_SB;
    end else begin
      bank_en       <= en_d;
      bank_we       <= cmd_valid && cmd_write;
      bank_row      <= cmd_valid ? cmd_row : '0;
      bank_col      <= cmd_valid ? cmd_col : '0;
      bank_wdata    <= (cmd_valid && cmd_write) ? (in_pim ? pu_wdata : host_wdata) : '0;
      pu_trig       <= cmd_valid && in_pim;
      pu_trig_write <= cmd_valid && in_pim && cmd_write;
      pu_row        <= (cmd_valid && in_pim) ? cmd_row : '0;
      pu_col        <= (cmd_valid && in_pim) ? cmd_col : '0;
      issued_mode_q <= mode_q;
    end
  end

  // Read return steering follows the mode in force when the data comes back.
  assign pu_rvalid   = bank_rvalid && in_pim;
  assign host_rvalid = bank_rvalid && !in_pim;
  assign pu_rdata    = pu_rvalid   ? bank_rdata : '0;
  assign host_rdata  = host_rvalid ? bank_rdata : '0;

  // R2
  sb_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_mode_q == MODE_SB) |-> $onehot0(bank_en));

  // R3
  bcast_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_mode_q != MODE_SB && bank_we) |-> $countones(bank_en) == HALF);

  // R7
  trig_only_pim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pu_trig |-> issued_mode_q == MODE_ABP);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> (bank_en == '0 && !bank_we));

  // R8
  rd_one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_rvalid && host_rvalid));

endmodule

// File: tb/pim_bank_router_tb_top.sv
module pim_bank_router_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_req_valid;
  logic [1:0]   mode_req_target;
  logic         cmd_valid;
  logic         cmd_write;
  logic [3:0]   cmd_bank;
  logic [13:0]  cmd_row;
  logic [4:0]   cmd_col;
  logic [255:0] host_wdata;
  logic [255:0] pu_wdata;
  logic         bank_rvalid;
  logic [255:0] bank_rdata;
  logic [1:0]   mode_cur;
  logic         mode_err;
  logic [15:0]  bank_en;
  logic         bank_we;
  logic [13:0]  bank_row;
  logic [4:0]   bank_col;
  logic [255:0] bank_wdata;
  logic         pu_trig;
  logic         pu_trig_write;
  logic [13:0]  pu_row;
  logic [4:0]   pu_col;
  logic         pu_rvalid;
  logic [255:0] pu_rdata;
  logic         host_rvalid;
  logic [255:0] host_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int model_mode = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pim_bank_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .mode_req_valid(mode_req_valid), .mode_req_target(mode_req_target),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col),
    .host_wdata(host_wdata), .pu_wdata(pu_wdata),
    .bank_rvalid(bank_rvalid), .bank_rdata(bank_rdata),
    .mode_cur(mode_cur), .mode_err(mode_err),
    .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row), .bank_col(bank_col),
    .bank_wdata(bank_wdata),
    .pu_trig(pu_trig), .pu_trig_write(pu_trig_write), .pu_row(pu_row), .pu_col(pu_col),
    .pu_rvalid(pu_rvalid), .pu_rdata(pu_rdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] want_en(input int mode, input bit wr, input int bank);
    bit spread;
    spread = (mode == 2) || (mode == 1 && wr);
    if (!spread) return 16'(1) << bank;
    return (bank % 2 == 1) ? 16'hAAAA : 16'h5555;
  endfunction

  function automatic logic [255:0] pat(input int seed);
    return {8{32'(seed * 32'h9E37_79B1 + 32'h0123_4567)}};
  endfunction

  // Issue one command, then check the registered outputs one edge later.
  task automatic do_cmd(input string req, input bit wr, input int bank);
    logic [13:0]  row;
    logic [4:0]   col;
    logic [255:0] exp_wd;
    row = 14'(bank * 613 + 7);
    col = 5'(bank * 3 + 1);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_write  = wr;
    cmd_bank   = 4'(bank);
    cmd_row    = row;
    cmd_col    = col;
    host_wdata = pat(bank + 100);
    pu_wdata   = pat(bank + 900);
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_wd = !wr ? 256'd0 : (model_mode == 2 ? pat(bank + 900) : pat(bank + 100));
    chk(req, "bank_en", 256'(bank_en), 256'(want_en(model_mode, wr, bank)));
    chk(req, "bank_we", 256'(bank_we), 256'(wr));
    chk(req, "bank_row", 256'(bank_row), 256'(row));
    chk(req, "bank_wdata", bank_wdata, exp_wd);
    chk("R7", "pu_trig", 256'(pu_trig), 256'(model_mode == 2));
    chk("R7", "pu_trig_write", 256'(pu_trig_write), 256'(model_mode == 2 && wr));
    chk("R7", "pu_col", 256'(pu_col), model_mode == 2 ? 256'(col) : 256'd0);
  endtask

  task automatic req_mode(input int tgt);
    bit legal;
    legal = (tgt == model_mode + 1 && model_mode < 2) || (tgt == model_mode - 1 && model_mode > 0);
    @(negedge clk);
    mode_req_valid  = 1'b1;
    mode_req_target = 2'(tgt);
    @(negedge clk);
    mode_req_valid = 1'b0;
    if (legal) model_mode = tgt;
    chk("R6", "mode_cur", 256'(mode_cur), 256'(model_mode));
    chk("R6", "mode_err", 256'(mode_err), 256'(!legal));
    @(negedge clk);
    chk("R6", "mode_err one cycle", 256'(mode_err), 256'd0);
  endtask

  task automatic rd_return(input int seed);
    @(negedge clk);
    bank_rvalid = 1'b1;
    bank_rdata  = pat(seed);
    #1;
    chk("R8", "pu_rvalid", 256'(pu_rvalid), 256'(model_mode == 2));
    chk("R8", "host_rvalid", 256'(host_rvalid), 256'(model_mode != 2));
    chk("R8", "pu_rdata", pu_rdata, model_mode == 2 ? pat(seed) : 256'd0);
    chk("R8", "host_rdata", host_rdata, model_mode != 2 ? pat(seed) : 256'd0);
    bank_rvalid = 1'b0;
  endtask

  task automatic sweep(input string req_wr, input string req_rd);
    for (int b = 0; b < 16; b++) begin
      do_cmd(req_wr, 1'b1, b);
      do_cmd(req_rd, 1'b0, b);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    mode_req_valid = 1'b0; mode_req_target = '0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_bank = '0; cmd_row = '0; cmd_col = '0;
    host_wdata = '0; pu_wdata = '0; bank_rvalid = 1'b0; bank_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "mode_cur", 256'(mode_cur), 256'd0);
    chk("R1", "bank_en", 256'(bank_en), 256'd0);
    chk("R1", "bank_we", 256'(bank_we), 256'd0);
    chk("R1", "bank_wdata", bank_wdata, 256'd0);
    chk("R1", "pu_trig", 256'(pu_trig), 256'd0);

    // R2: single-bank sweep
    sweep("R2", "R2");
    // R10: no command, outputs quiet
    @(negedge clk);
    chk("R10", "bank_en idle", 256'(bank_en), 256'd0);
    chk("R10", "bank_we idle", 256'(bank_we), 256'd0);
    rd_return(1);

    // R6: refused requests from single-bank
    req_mode(2);
    req_mode(0);
    req_mode(3);
    req_mode(1);

    // R3 / R4: all-bank sweep
    sweep("R3", "R4");
    rd_return(2);
    req_mode(1);
    req_mode(3);

    // R9: write on the same edge as the step into PIM routes by all-bank rules
    @(negedge clk);
    mode_req_valid  = 1'b1;
    mode_req_target = 2'd2;
    cmd_valid  = 1'b1; cmd_write = 1'b1; cmd_bank = 4'd3;
    cmd_row = 14'd55; cmd_col = 5'd9;
    host_wdata = pat(77); pu_wdata = pat(78);
    @(negedge clk);
    mode_req_valid = 1'b0;
    cmd_valid = 1'b0;
    chk("R9", "bank_en", 256'(bank_en), 256'(16'hAAAA));
    chk("R9", "bank_wdata host", bank_wdata, pat(77));
    chk("R9", "no trigger", 256'(pu_trig), 256'd0);
    chk("R9", "mode_cur", 256'(mode_cur), 256'd2);
    model_mode = 2;

    // R5 / R7: PIM sweep
    sweep("R5", "R5");
    @(negedge clk);
    chk("R7", "pu_trig one cycle", 256'(pu_trig), 256'd0);
    chk("R10", "bank_en idle pim", 256'(bank_en), 256'd0);
    rd_return(3);

    // R6: downward ladder with refusals
    req_mode(0);
    req_mode(2);
    req_mode(1);
    do_cmd("R4", 1'b0, 6);
    req_mode(0);
    do_cmd("R2", 1'b1, 11);
    rd_return(4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule